// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a four-wire configuration port that loads and reads back a small bank of eight-bit control registers. A host lowers an active-low enable, then sends 16-bit words, most significant bit first, clocked on the rising edge of a slow serial clock. In each word the top bit selects the direction, the next seven bits give the register address and the low byte carries the data. A write word updates its register once its sixteenth bit arrives. A read word sends the addressed register back on a serial output during the second half of the same word.

All three serial inputs are brought into a faster system clock through two-flop synchronizers. Edges of the serial clock are found in that domain, so the system clock must run at least four times faster than the serial clock. The register contents are presented in parallel to the rest of the chip. A dedicated bit restores every register to its power-up value and then reads back as zero. A synchronous active-high reset does the same and also cancels any word that is only partly received.

The serial output comes with a separate enable, so the pad ring can leave the pin floating whenever the enable is low.

Top module: `sreg_port`

## Requirements
- R1: After `rst`, every register reads zero except register 14, which holds 8'h40 (a three-bit subclass field in bits 7:5 equal to 3'b010), and `sdout_oe` is low.
- R2: Shifting takes place only while `sen` is low. Serial-clock edges while `sen` is high neither advance the bit count nor change any register.
- R3: A word is bit 15 = direction (0 = write), bits 14:8 = address, bits 7:0 = data, sent MSB first. A write commits on the 16th rising `sclk` edge of the word and appears on `cfg_regs` after the 4th rising `clk` edge that follows the rising `sclk` pin edge. `cfg_regs` changes only when a write commits.
- R4: One enable window can carry several words. Every 16th rising edge in the window commits the word just completed.
- R5: Fewer than 16 bits left in a window when `sen` rises are discarded. The next window starts again at bit 15 of a new word.
- R6: For a read word (bit 15 = 1), the addressed register is sent MSB first on `sdout`. Each bit is updated on the `sclk` falling edges that follow rising edges 8 to 15. `sdout_oe` is high from the fall after rising edge 8 until the fall after rising edge 16, or until `sen` rises.
- R7: `sdout_oe` stays low for the whole of every write word.
- R8: A read word leaves every register unchanged, whatever its data byte holds.
- R9: A write to register 0 with bit 0 set returns all registers to their R1 values. Register 0 then reads 0, so the bit clears itself.
- R10: Addresses 16 and above hold no register. Writes to them change nothing, and reads from them return 8'h00.
- R11: `rst` in the middle of a word discards the partial word as well as restoring the R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sen | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock; data sampled on rising edges |
| sdata | input | 1 | Serial data in |
| sdout | output | 1 | Serial readback data |
| sdout_oe | output | 1 | Drive enable for the readback pin; low means high-impedance |
| cfg_regs | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
Every serial pin passes through two synchronizer flops. After that, one more register is needed to update `sdout` and `sdout_oe`, and a write needs two more before it lands in `cfg_regs`. So `sdout` is due three system edges after an `sclk` pin edge, and a register update is due four edges after the final rising `sclk` edge. The bench reference model runs the pin values through a two-entry queue and holds each write for one extra step. It compares all outputs at every falling `clk` edge. One directed check samples `cfg_regs` after the third and fourth edges that follow the final rising edge of a word, to confirm the exact latency. Readback bits are sampled at the end of each low `sclk` phase, well after they are due.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned BYTE_W = WORD_W / 2;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    byte_t             data;
  } wr_req_t;

  // Power-up content of register idx
  function automatic byte_t reg_default(input int idx, input int sub_idx, input byte_t sub_val);
    return (idx == sub_idx) ? sub_val : '0;
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sen_act,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdata_s,
  input  byte_t             rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output wr_req_t           wr_req,
  output logic              sdout,
  output logic              sdout_oe
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rd_mode;
  byte_t             rd_shift;
  logic [WORD_W-1:0] word_now;
  logic              addr_done;
  logic              word_done;

  assign word_now  = {shreg, sdata_s};
  assign addr_done = rise && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign word_done = rise && (bit_cnt == CNT_W'(WORD_W - 1));
  assign rd_addr   = word_now[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      rd_mode  <= 1'b0;
      rd_shift <= '0;
      wr_req   <= '0;
      sdout    <= 1'b0;
      sdout_oe <= 1'b0;
    end else begin
      wr_req.vld <= 1'b0;
      if (!sen_act) begin
        bit_cnt  <= '0;
        rd_mode  <= 1'b0;
        sdout_oe <= 1'b0;
      end else if (rise) begin
        shreg   <= word_now[WORD_W-2:0];
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (addr_done && word_now[BYTE_W-1]) begin
          rd_mode  <= 1'b1;
          rd_shift <= rd_data;
        end
        if (word_done) begin
          rd_mode <= 1'b0;
          if (!word_now[WORD_W-1]) begin
            wr_req.vld  <= 1'b1;
            wr_req.addr <= word_now[WORD_W-2:BYTE_W];
            wr_req.data <= word_now[BYTE_W-1:0];
          end
        end
      end else if (fall) begin
        sdout_oe <= rd_mode;
        if (rd_mode) begin
          sdout    <= rd_shift[BYTE_W-1];
          rd_shift <= {rd_shift[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter int    NUM_REGS = 16,
  parameter int    SUB_IDX  = 14,
  parameter byte_t SUB_VAL  = 8'h40,
  parameter int    RST_IDX  = 0,
  parameter int    RST_BIT  = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wr_req_t                    wr_req,
  input  logic [ADDR_W-1:0]          rd_addr,
  output byte_t                      rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  byte_t mem [NUM_REGS];
  logic  hit_wr;
  logic  soft_rst;

  assign hit_wr   = wr_req.vld && (int'(wr_req.addr) < NUM_REGS);
  assign soft_rst = hit_wr && (int'(wr_req.addr) == RST_IDX) && wr_req.data[RST_BIT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst || soft_rst)
        mem[i] <= reg_default(i, SUB_IDX, SUB_VAL);
      else if (hit_wr && (int'(wr_req.addr) == i))
        mem[i] <= wr_req.data;
    end
  end

  assign rd_data = (int'(rd_addr) < NUM_REGS) ? mem[rd_addr[IDX_W-1:0]] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_o[g*BYTE_W +: BYTE_W] = mem[g];
  end
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int    NUM_REGS = 16,
  parameter int    SUB_IDX  = 14,
  parameter byte_t SUB_VAL  = 8'h40,
  parameter int    RST_IDX  = 0,
  parameter int    RST_BIT  = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sen,
  input  logic                       sclk,
  input  logic                       sdata,
  output logic                       sdout,
  output logic                       sdout_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
  logic              sclk_s, sen_s, sdata_s, sclk_q;
  logic              sclk_rise, sclk_fall;
  wr_req_t           wr_req;
  logic [ADDR_W-1:0] rd_addr;
  byte_t             rd_data;

  sreg_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk, sen, sdata}),
    .q   ({sclk_s, sen_s, sdata_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  sreg_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .sen_act  (~sen_s),
    .rise     (sclk_rise),
    .fall     (sclk_fall),
    .sdata_s  (sdata_s),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_req   (wr_req),
    .sdout    (sdout),
    .sdout_oe (sdout_oe)
  );

  sreg_file #(
    .NUM_REGS (NUM_REGS),
    .SUB_IDX  (SUB_IDX),
    .SUB_VAL  (SUB_VAL),
    .RST_IDX  (RST_IDX),
    .RST_BIT  (RST_BIT)
  ) u_file (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .regs_o  (cfg_regs)
  );
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk
  import sreg_pkg::*;
#(
  parameter int    NUM_REGS = 16,
  parameter int    SUB_IDX  = 14,
  parameter byte_t SUB_VAL  = 8'h40,
  parameter int    RST_IDX  = 0,
  parameter int    RST_BIT  = 0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sen_s,
  input logic                       sclk_fall,
  input logic                       wr_vld,
  input logic [ADDR_W-1:0]          wr_addr,
  input byte_t                      wr_data,
  input logic                       sdout,
  input logic                       sdout_oe,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
  logic [NUM_REGS*BYTE_W-1:0] exp_def;
  logic                       soft_req;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_def
    assign exp_def[g*BYTE_W +: BYTE_W] = reg_default(g, SUB_IDX, SUB_VAL);
  end

  assign soft_req = wr_vld && (int'(wr_addr) == RST_IDX) && wr_data[RST_BIT];

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_regs == exp_def)) else $error("reset defaults"); // R1

  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    sdout_oe |-> $past(!sen_s)) else $error("oe outside window"); // R2

  AST_CFG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cfg_regs)) |-> $past(wr_vld)) else $error("cfg change w/o write"); // R3

  AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sdout)) |-> $past(sclk_fall)) else $error("sdout off fall"); // R6

  AST_NO_OE_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> !sdout_oe) else $error("oe during write"); // R7

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(soft_req)) |-> (cfg_regs == exp_def)) else $error("soft reset"); // R9
endmodule

bind sreg_port sreg_port_chk #(
  .NUM_REGS (NUM_REGS),
  .SUB_IDX  (SUB_IDX),
  .SUB_VAL  (SUB_VAL),
  .RST_IDX  (RST_IDX),
  .RST_BIT  (RST_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sen_s     (sen_s),
  .sclk_fall (sclk_fall),
  .wr_vld    (wr_req.vld),
  .wr_addr   (wr_req.addr),
  .wr_data   (wr_req.data),
  .sdout     (sdout),
  .sdout_oe  (sdout_oe),
  .cfg_regs  (cfg_regs)
);

// File: tb/sreg_port_bench.sv
module sreg_port_bench;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sen = 1'b1;
  logic sclk = 1'b0;
  logic sdata = 1'b0;
  logic sdout, sdout_oe;
  logic [NREG*8-1:0] cfg_regs;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit oe_seen = 0;

  always #5 clk = ~clk;

  sreg_port u_sreg_port (
    .clk (clk), .rst (rst), .sen (sen), .sclk (sclk), .sdata (sdata),
    .sdout (sdout), .sdout_oe (sdout_oe), .cfg_regs (cfg_regs)
  );

  // ---------------- reference model ----------------
  logic cap_rst = 1'b1, cap_sclk = 1'b0, cap_sen = 1'b1, cap_sdata = 1'b0;
  always @(posedge clk) begin
    cap_rst   <= rst;
    cap_sclk  <= sclk;
    cap_sen   <= sen;
    cap_sdata <= sdata;
  end

  logic [2:0]  pinq[$];
  logic [2:0]  e;
  logic [7:0]  mregs [NREG];
  logic [15:0] mword;
  int          bits;
  bit          rdm, m_oe, m_sdo, prev_sclk;
  logic [7:0]  rdb;
  bit          pv, nv;
  logic [6:0]  pa, na;
  logic [7:0]  pd, nd;
  bit          bad;

  function automatic logic [7:0] dflt(input int i);
    return (i == 14) ? 8'h40 : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (cap_rst) begin
      for (int i = 0; i < NREG; i++) mregs[i] = dflt(i);
      pinq = {3'b010, 3'b010};
      bits = 0; rdm = 0; m_oe = 0; m_sdo = 0; prev_sclk = 0; pv = 0; mword = '0; rdb = '0;
    end else begin
      pinq.push_back({cap_sclk, cap_sen, cap_sdata});
      e  = pinq.pop_front();
      nv = 0; na = '0; nd = '0;
      if (e[1]) begin
        bits = 0; rdm = 0; m_oe = 0;
      end else if (e[2] && !prev_sclk) begin
        mword = {mword[14:0], e[0]};
        bits++;
        if (bits == 8 && mword[7]) begin
          rdm = 1;
          rdb = (int'(mword[6:0]) < NREG) ? mregs[mword[6:0]] : 8'h00;
        end
        if (bits == 16) begin
          bits = 0; rdm = 0;
          if (!mword[15]) begin nv = 1; na = mword[14:8]; nd = mword[7:0]; end
        end
      end else if (!e[2] && prev_sclk) begin
        m_oe = rdm;
        if (rdm) begin m_sdo = rdb[7]; rdb = {rdb[6:0], 1'b0}; end
      end
      prev_sclk = e[2];
      if (pv && int'(pa) < NREG) begin
        if (pa == 0 && pd[0]) for (int i = 0; i < NREG; i++) mregs[i] = dflt(i);
        else mregs[pa] = pd;
      end
      pv = nv; pa = na; pd = nd;
    end
    // compare every clock
    bad = 0;
    for (int i = 0; i < NREG; i++)
      if (cfg_regs[i*8 +: 8] !== mregs[i]) begin
        bad = 1;
        $display("FAIL %s reg%0d actual=%h expected=%h", cur_req, i, cfg_regs[i*8 +: 8], mregs[i]);
      end
    if (sdout_oe !== m_oe) begin
      bad = 1;
      $display("FAIL %s sdout_oe actual=%b expected=%b", cur_req, sdout_oe, m_oe);
    end
    if (m_oe && sdout !== m_sdo) begin
      bad = 1;
      $display("FAIL %s sdout actual=%b expected=%b", cur_req, sdout, m_sdo);
    end
    compared++;
    if (bad) mismatched++;
    if (sdout_oe === 1'b1) oe_seen = 1;
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg(input int i);
    return cfg_regs[i*8 +: 8];
  endfunction

  task automatic xfer(input logic [15:0] w, input int nbits, output logic [7:0] rb);
    rb = '0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; sdata = w[15-i];
      repeat (4) @(negedge clk);
      if (i >= 8) rb = {rb[6:0], sdout};
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic open_win();
    sen = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic close_win();
    sen = 1'b1; repeat (6) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rb;
    open_win(); xfer({1'b0, a, d}, 16, rb); close_win();
  endtask

  task automatic rd_reg(input logic [6:0] a, input logic [7:0] junk, output logic [7:0] rb);
    open_win(); xfer({1'b1, a, junk}, 16, rb); close_win();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // ---------------- tests ----------------
  initial begin
    logic [7:0] rb;
    logic [NREG*8-1:0] snap;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    cur_req = "R1";
    chk("R1 reg14", cfg(14), 8'h40);
    chk("R1 reg0", cfg(0), 8'h00);
    chk("R1 oe", sdout_oe, 0);

    // R3: exact commit latency
    cur_req = "R3";
    oe_seen = 0;
    open_win();
    xfer({1'b0, 7'd3, 8'hA5}, 15, rb);
    sdata = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 before commit", cfg(3), 8'h00);
    @(negedge clk);
    chk("R3 after commit", cfg(3), 8'hA5);
    sclk = 1'b0; repeat (4) @(negedge clk);
    close_win();
    chk("R7 oe low in write", oe_seen, 0);

    // R4: two words in one window
    cur_req = "R4";
    open_win();
    xfer({1'b0, 7'd1, 8'h11}, 16, rb);
    xfer({1'b0, 7'd2, 8'h22}, 16, rb);
    close_win();
    chk("R4 word1", cfg(1), 8'h11);
    chk("R4 word2", cfg(2), 8'h22);

    // R5: trailing partial word dropped
    cur_req = "R5";
    open_win();
    xfer({1'b0, 7'd4, 8'h44}, 16, rb);
    xfer({1'b0, 7'd5, 8'h55}, 10, rb);
    close_win();
    wr_reg(7'd6, 8'h66);
    chk("R5 full word", cfg(4), 8'h44);
    chk("R5 partial dropped", cfg(5), 8'h00);
    chk("R5 fresh start", cfg(6), 8'h66);

    // R2: clocks with enable high ignored
    cur_req = "R2";
    xfer({1'b0, 7'd7, 8'h77}, 16, rb);
    repeat (6) @(negedge clk);
    chk("R2 no write", cfg(7), 8'h00);
    wr_reg(7'd8, 8'h88);
    chk("R2 count untouched", cfg(8), 8'h88);

    // R6: readback
    cur_req = "R6";
    rd_reg(7'd3, 8'h00, rb);
    chk("R6 read reg3", rb, 8'hA5);
    rd_reg(7'd14, 8'h00, rb);
    chk("R6 read reg14", rb, 8'h40);
    chk("R6 oe dropped", sdout_oe, 0);

    // R8: read word with data bits does not write
    cur_req = "R8";
    rd_reg(7'd3, 8'hFF, rb);
    chk("R8 reg3 kept", cfg(3), 8'hA5);

    // R10: out-of-range address
    cur_req = "R10";
    snap = cfg_regs;
    wr_reg(7'h50, 8'h99);
    chk("R10 no change", (cfg_regs == snap), 1);
    rd_reg(7'h50, 8'h00, rb);
    chk("R10 read zero", rb, 8'h00);

    // R9: reset register without/with bit 0
    cur_req = "R9";
    wr_reg(7'd0, 8'h02);
    chk("R9 plain write reg0", cfg(0), 8'h02);
    chk("R9 others kept", cfg(3), 8'hA5);
    wr_reg(7'd0, 8'h01);
    chk("R9 reg3 default", cfg(3), 8'h00);
    chk("R9 reg14 default", cfg(14), 8'h40);
    rd_reg(7'd0, 8'h00, rb);
    chk("R9 self clear", rb, 8'h00);

    // R11: reset mid-word
    cur_req = "R11";
    wr_reg(7'd3, 8'h33);
    open_win();
    xfer({1'b0, 7'd9, 8'h5A}, 9, rb);
    rst = 1'b1; sen = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 defaults", cfg(3), 8'h00);
    chk("R11 reg14", cfg(14), 8'h40);
    wr_reg(7'd9, 8'h99);
    chk("R11 partial aborted", cfg(9), 8'h99);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule